// File: doc/BRIEF.md
# Pipelined Modular Squarer

This block returns the residue of an operand squared, taken modulo a constant modulus fixed when the block is built. The operand is unsigned and already lies below the modulus. No multiplier and no divider appear anywhere in the datapath.

Squaring is symmetric, so the partial products shrink to one diagonal bit per operand bit and one doubled cross bit per pair of operand bits. Each of these bits has a weight of two to some power. That weight is replaced at elaboration time by its residue modulo the modulus, which follows the repeating cycle of powers of two. The resulting terms are summed by a balanced adder tree with a register after every adder level. A last reduction stage then brings the sum below the modulus. Three cases are handled:

- For a modulus of the form 2^n−1 it folds the high bits back with end-around carry.
- For a power of two it keeps the low bits.
- For any other modulus it compares the sum with shifted multiples of the modulus and subtracts.

A valid flag travels alongside the data. One operand may enter on every cycle.

Top module: `sqm_top`

## Requirements
- R1: When an output is flagged valid, `out_res` equals (X·X) mod MODULUS, where X is the operand that entered with it. This holds for every X in [0, MODULUS−1] and for every MODULUS of at least 3.
- R2: Latency is a fixed LAT = clog2(XW·(XW+1)/2) + 2 cycles, where XW = clog2(MODULUS). An operand sampled with `in_valid` high at a rising edge appears with `out_valid` high right after the LAT-th rising edge that follows it.
- R3: The block accepts a new operand on every cycle. A run of back-to-back operands produces exactly as many valid results, also back to back.
- R4: `out_valid` is high in a cycle exactly when `in_valid` was high LAT cycles earlier. While `in_valid` is low, the value on `in_x` has no effect on any output.
- R5: A synchronous reset (`rst` high at a rising edge) forces `out_valid` low and discards every operand still inside the pipeline.
- R6: Whenever `out_valid` is high, `out_res` is strictly below MODULUS. For a modulus of the form 2^n−1, the all-ones code therefore never appears.
- R7: A modulus of the form 2^n−1 (for example 3 or 31) gives results that satisfy R1. These results rely on end-around carry and the mapping of all-ones to zero.
- R8: A modulus that is a power of two (for example 16) gives results that satisfy R1.
- R9: A modulus of the form 2^(n−1)+1 (for example 17) and other odd moduli (for example 13) give results that satisfy R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `in_x` as an operand to square |
| in_x | input | XW | Unsigned operand, expected below MODULUS |
| out_valid | output | 1 | Marks `out_res` as a finished result |
| out_res | output | XW | Residue of the operand squared |

## Verification
Some properties are checked on every clock:
- Each valid result lies below the modulus.
- The number of operands in flight never exceeds the latency.
- The cycle after reset carries no valid result.
- For a modulus of the form 2^n−1, the reduced value is never all ones.
- The sum leaving the adder tree and the reduced residue are congruent modulo the modulus.

Only the bench scenarios can show the rest. These are:
- The exact numeric result for each operand, across five moduli from all three classes.
- The exact latency and back-to-back throughput.
- That idle-cycle operand values are ignored.
- That a mid-stream reset discards in-flight work.

// File: rtl/sqm_pkg.sv
package sqm_pkg;

   // residue of 2**k modulo m, computed by stepping through the power cycle
   function automatic int unsigned pow2_mod(input int unsigned k, input int unsigned m);
      int unsigned r;
      r = 1 % m;
      for (int unsigned i = 0; i < k; i++) r = (r * 2) % m;
      return r;
   endfunction

   function automatic bit is_pow2(input int unsigned v);
      return (v & (v - 1)) == 0;
   endfunction

   function automatic bit is_mersenne(input int unsigned v);
      return ((v + 1) & v) == 0;
   endfunction

   // slot of the cross term (i,j), i<j, among the n*(n-1)/2 cross terms
   function automatic int unsigned cross_slot(input int unsigned i, input int unsigned j,
                                              input int unsigned n);
      return (i * (2 * n - i - 1)) / 2 + (j - i - 1);
   endfunction

endpackage

// File: rtl/sqm_fold.sv
module sqm_fold
   import sqm_pkg::*;
#(
   parameter int unsigned MODULUS = 13,
   parameter int unsigned XW      = 4,
   parameter int unsigned NT_P    = 16,
   parameter int unsigned SW      = 8
) (
   input  logic [XW-1:0]      x,
   output logic [NT_P*SW-1:0] terms
);

   localparam int unsigned NT = XW * (XW + 1) / 2;

   genvar i, j, p;
   generate
      // diagonal bits: x_i * x_i = x_i at weight 2^(2i)
      for (i = 0; i < XW; i++) begin : g_diag
         localparam logic [SW-1:0] WGT = SW'(pow2_mod(2 * i, MODULUS));
         assign terms[i*SW +: SW] = x[i] ? WGT : '0;
      end
      // cross bits: x_i & x_j appear twice, hence weight 2^(i+j+1)
      for (i = 0; i < XW; i++) begin : g_row
         for (j = i + 1; j < XW; j++) begin : g_col
            localparam int unsigned SLOT = XW + cross_slot(i, j, XW);
            localparam logic [SW-1:0] WGT = SW'(pow2_mod(i + j + 1, MODULUS));
            assign terms[SLOT*SW +: SW] = (x[i] & x[j]) ? WGT : '0;
         end
      end
      // pad to a full power-of-two leaf count
      for (p = NT; p < NT_P; p++) begin : g_pad
         assign terms[p*SW +: SW] = '0;
      end
   endgenerate

endmodule

// File: rtl/sqm_tree.sv
module sqm_tree #(
   parameter int unsigned SW     = 8,
   parameter int unsigned LEVELS = 2
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       in_valid,
   input  logic [(1<<LEVELS)*SW-1:0]  leaves,
   output logic                       out_valid,
   output logic [SW-1:0]              sum
);

   localparam int unsigned NT_P = 1 << LEVELS;
   localparam int unsigned NI   = NT_P - 1;   // internal adder nodes, heap order

   logic [NI*SW-1:0] nodes;
   logic [LEVELS-1:0] vsr;

   genvar n;
   generate
      for (n = 0; n < NI; n++) begin : g_node
         localparam int unsigned LC = 2 * n + 1;
         localparam int unsigned RC = 2 * n + 2;
         logic [SW-1:0] a, b, r;
         if (LC >= NI) begin : g_leaf
            assign a = leaves[(LC-NI)*SW +: SW];
            assign b = leaves[(RC-NI)*SW +: SW];
         end else begin : g_inner
            assign a = nodes[LC*SW +: SW];
            assign b = nodes[RC*SW +: SW];
         end
         // one adder per level, then a register
         always_ff @(posedge clk) r <= a + b;
         assign nodes[n*SW +: SW] = r;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) vsr <= '0;
      else     vsr <= {vsr[LEVELS-2:0], in_valid};
   end

   assign out_valid = vsr[LEVELS-1];
   assign sum       = nodes[SW-1:0];

endmodule

// File: rtl/sqm_reduce.sv
module sqm_reduce
   import sqm_pkg::*;
#(
   parameter int unsigned MODULUS = 13,
   parameter int unsigned SW      = 8,
   parameter int unsigned XW      = 4
) (
   input  logic [SW-1:0] s,
   output logic [XW-1:0] r
);

   generate
      if (is_pow2(MODULUS)) begin : g_pow2
         logic unused_hi;
         assign unused_hi = ^s[SW-1:XW];
         assign r = s[XW-1:0];
      end else if (is_mersenne(MODULUS)) begin : g_mers
         localparam int unsigned FOLDS = SW / XW + 2;
         logic [SW-1:0] acc;
         always_comb begin
            acc = s;
            for (int f = 0; f < FOLDS; f++)
               acc = SW'(acc[XW-1:0]) + (acc >> XW);   // end-around carry
            r = (acc[XW-1:0] == '1) ? '0 : acc[XW-1:0];
         end
      end else begin : g_generic
         logic [SW-1:0] acc;
         always_comb begin
            acc = s;
            for (int j = SW - XW; j >= 0; j--)
               if (acc >= (SW'(MODULUS) << j)) acc = acc - (SW'(MODULUS) << j);
            r = acc[XW-1:0];
         end
      end
   endgenerate

endmodule

// File: rtl/sqm_top.sv
module sqm_top
   import sqm_pkg::*;
#(
   parameter int unsigned MODULUS = 13
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         in_valid,
   input  logic [$clog2(MODULUS)-1:0]   in_x,
   output logic                         out_valid,
   output logic [$clog2(MODULUS)-1:0]   out_res
);

   localparam int unsigned XW     = $clog2(MODULUS);
   localparam int unsigned NT     = XW * (XW + 1) / 2;
   localparam int unsigned LEVELS = $clog2(NT);
   localparam int unsigned NT_P   = 1 << LEVELS;
   localparam int unsigned SW     = XW + LEVELS;
   localparam int unsigned LAT    = LEVELS + 2;
   localparam int unsigned FW     = $clog2(LAT + 1) + 1;

   generate
      if (MODULUS < 3) begin : g_chk_min
         $error("sqm_top: MODULUS must be at least 3");
      end
      if (MODULUS >= (1 << 24)) begin : g_chk_max
         $error("sqm_top: MODULUS too large for the default tree sizing");
      end
   endgenerate

   logic                 v_q;
   logic [XW-1:0]        x_q;
   logic [NT_P*SW-1:0]   terms;
   logic                 tree_v;
   logic [SW-1:0]        tree_sum;
   logic [XW-1:0]        red_r;

   always_ff @(posedge clk) begin
      if (rst) v_q <= 1'b0;
      else     v_q <= in_valid;
      x_q <= in_x;
   end

   sqm_fold #(.MODULUS(MODULUS), .XW(XW), .NT_P(NT_P), .SW(SW)) fold_i (
      .x     (x_q),
      .terms (terms)
   );

   sqm_tree #(.SW(SW), .LEVELS(LEVELS)) tree_i (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (v_q),
      .leaves    (terms),
      .out_valid (tree_v),
      .sum       (tree_sum)
   );

   sqm_reduce #(.MODULUS(MODULUS), .SW(SW), .XW(XW)) red_i (
      .s (tree_sum),
      .r (red_r)
   );

   always_ff @(posedge clk) begin
      if (rst) out_valid <= 1'b0;
      else     out_valid <= tree_v;
      out_res <= red_r;
   end

   // ---------------- assertions ----------------
   logic [FW-1:0] inflight;
   always_ff @(posedge clk) begin
      if (rst) inflight <= '0;
      else     inflight <= inflight + FW'(in_valid) - FW'(out_valid);
   end

   always_ff @(posedge clk) begin
      if (!rst && tree_v)
         AST_RED_CONGRUENT: assert ((tree_sum % SW'(MODULUS)) == SW'(red_r)) // R1
            else $error("reduced value not congruent to tree sum");
   end

   AST_RES_BELOW_A: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (32'(out_res) < MODULUS)); // R6

   AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (rst)
      32'(inflight) <= LAT); // R2

   AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !out_valid); // R5

   generate
      if (is_mersenne(MODULUS)) begin : g_mers_chk
         AST_MERS_NO_ONES: assert property (@(posedge clk) disable iff (rst)
            tree_v |=> (out_res != '1)); // R7
      end
   endgenerate

endmodule

// File: tb/sqm_top_tb.sv
module sqm_top_tb_top;

   localparam int NL = 5;
   localparam int unsigned MODS [NL] = '{31, 16, 17, 13, 3};

   localparam int PH_RESET = 0, PH_SWEEP = 1, PH_RAND = 2, PH_DRAIN = 3;
   localparam int END_CYC  = 640;

   logic clk = 1'b0;
   logic rst = 1'b1;
   int   cyc = 0;
   int   errors = 0;
   int   checks = 0;

   always #10 clk = ~clk;   // 50 MHz
   always @(posedge clk) cyc <= cyc + 1;

   function automatic int phase_of(input int c);
      if (c < 4)   return PH_RESET;
      if (c < 40)  return PH_SWEEP;
      if (c < 300) return PH_RAND;
      if (c < 303) return PH_RESET;   // mid-stream reset
      if (c < 600) return PH_RAND;
      return PH_DRAIN;
   endfunction

   function automatic string class_tag(input int unsigned a);
      if ((a & (a - 1)) == 0) return "R8";
      if (((a + 1) & a) == 0) return "R7";
      return "R9";
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp,
                        input int unsigned a);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s (modulus %0d): actual=%0d expected=%0d", req, a, act, exp);
      end
   endtask

   initial begin
      void'($urandom(32'd5150));
   end

   always @(negedge clk) begin
      rst <= (phase_of(cyc) == PH_RESET);
      if (cyc >= END_CYC) begin
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      errors++;
      $display("FAIL R3 watchdog expired: actual cycle=%0d expected below %0d", cyc, END_CYC);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   genvar m;
   generate
      for (m = 0; m < NL; m++) begin : g_lane
         localparam int unsigned A   = MODS[m];
         localparam int          XW  = $clog2(A);
         localparam int          NT  = XW * (XW + 1) / 2;
         localparam int          LAT = $clog2(NT) + 2;   // R2 formula

         logic          v = 1'b0;
         logic [XW-1:0] x = '0;
         logic          ov;
         logic [XW-1:0] ores;
         bit            hv [16];
         int            hx [16];
         int            sweep_cnt = 0;
         bit            after_rst = 1'b0;

         if (m == 0) begin : g_main
            sqm_top #(.MODULUS(A)) dut_i (
               .clk(clk), .rst(rst), .in_valid(v), .in_x(x),
               .out_valid(ov), .out_res(ores));
         end else begin : g_aux
            sqm_top #(.MODULUS(A)) dut_i (
               .clk(clk), .rst(rst), .in_valid(v), .in_x(x),
               .out_valid(ov), .out_res(ores));
         end

         initial for (int k = 0; k < 16; k++) begin hv[k] = 1'b0; hx[k] = 0; end

         always @(negedge clk) begin
            int c;
            int ph;
            int e;
            c  = cyc;
            ph = phase_of(c);
            if (c >= 1) begin
               // R2 / R4 / R5: valid appears exactly LAT cycles after an accepted operand
               if (ph == PH_RESET || after_rst)
                  check(ov === hv[LAT-1], "R5", int'(ov), int'(hv[LAT-1]), A);
               else
                  check(ov === hv[LAT-1], "R2,R4", int'(ov), int'(hv[LAT-1]), A);
               if (hv[LAT-1] && ov === 1'b1) begin
                  e = (hx[LAT-1] * hx[LAT-1]) % int'(A);
                  check(int'(ores) == e, {"R1,", class_tag(A)}, int'(ores), e, A);
                  check(32'(ores) < A, "R6", int'(ores), int'(A) - 1, A);
               end
               if (ov === 1'b1 && c >= 4 + LAT && c < 4 + int'(A) + LAT) sweep_cnt++;
               // R3: the back-to-back sweep yields one result per operand
               if (c == 4 + int'(A) + LAT)
                  check(sweep_cnt == int'(A), "R3", sweep_cnt, int'(A), A);
            end
            after_rst = (ph == PH_RESET) ? 1'b1 : (after_rst && c < 303 + LAT);
            if (c < 300 || c >= 303 + LAT) after_rst = (ph == PH_RESET) && c >= 300;
            for (int k = 15; k > 0; k--) begin hv[k] = hv[k-1]; hx[k] = hx[k-1]; end
            if (ph == PH_RESET) for (int k = 0; k < 16; k++) hv[k] = 1'b0;
            case (ph)
               PH_SWEEP: begin
                  v = (c - 4) < int'(A);
                  x = v ? XW'(c - 4) : XW'($urandom);
               end
               PH_RAND: begin
                  v = ($urandom % 4) != 0;
                  // idle cycles carry junk operands that must be ignored (R4)
                  x = v ? XW'($urandom % A) : XW'($urandom);
               end
               default: begin
                  v = 1'b0;
                  x = XW'($urandom);
               end
            endcase
            hv[0] = v;
            hx[0] = int'(x);
         end
      end
   endgenerate

endmodule